// File: doc/BRIEF.md
# External Interrupt Request Controller

This block takes six asynchronous interrupt pins from outside the chip and turns each one into a latched request for the interrupt controller. Each channel can trigger on a single edge, on both edges, or on a level. It resynchronizes every pin to the core clock and watches for the condition set for that channel. When the condition occurs, it sets a sticky request flag that stays high until the CPU acknowledges the channel or software clears it.

Software configures the block through a small byte-wide register port. Addresses 0 to 5 each hold one channel's control byte: trigger kind, polarity, and the readable request flag. Address 6 holds a shared byte. Its bit *n* (n = 0..5) switches channel *n* to both-edge triggering. Bits 6 and 7 of that byte are plain storage. Each request flag also appears on a dedicated output, and each channel has an acknowledge input that clears it.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every request output is 0 and every readable address (0..6) returns 0x00. This means falling-edge triggering on all channels and single-edge mode everywhere.
- R2: In single-edge mode with polarity 0 (control bit 1 = 0, control bit 0 = 0), a falling pin edge sets the channel's request and a rising edge does not.
- R3: In single-edge mode with polarity 1 (control bit 1 = 1), a rising pin edge sets the request and a falling edge does not.
- R4: When bit n of the shared byte at address 6 is 1, channel n sets its request on both rising and falling edges.
- R5: In level mode (control bit 0 = 1), the request sets while the pin sits at the level chosen by control bit 1 (0 = low, 1 = high). Once set, the request stays at 1 after the pin leaves that level.
- R6: A one-cycle pulse on a channel's acknowledge input clears that channel's request and no other channel's.
- R7: Writing a control byte with bit 2 = 0 clears that channel's request. Writing bit 2 = 1 never sets it. Bit 2 reads back as the current request.
- R8: If a trigger event and an acknowledge hit the same channel in the same cycle, the request stays set.
- R9: Bits 6 and 7 of the shared byte are stored and read back, but they change no channel's triggering.
- R10: A trigger on one channel sets only that channel's request.
- R11: A pin change that is stable before clock edge k shows on the request output after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_pin | input | 6 | Asynchronous external interrupt pins |
| irq_ack | input | 6 | Per-channel acknowledge, one-cycle pulse |
| irq_req | output | 6 | Latched per-channel interrupt requests |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0..5 channel control, 6 shared both-edge byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |

## Verification
The assertions assume that software never pairs level mode with both-edge mode on a channel, and they flag that combination when it occurs. They also assume that acknowledges arrive as single pulses on one channel at a time. The stimulus only enables both-edge mode on a channel configured for edge triggering. It keeps every pin at a steady value from reset until the synchronizer is primed, and it holds each new pin value for at least three clocks, so every edge is seen exactly once.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned CTRL_MODE_BIT = 0;
  localparam int unsigned CTRL_POL_BIT  = 1;
  localparam int unsigned CTRL_REQ_BIT  = 2;
  localparam int unsigned PRIME_STAGES  = 3;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_kind_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync
  import eirq_pkg::*;
#(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall,
  output logic             primed
);
  logic [WIDTH-1:0]        meta_q, meta_d;
  logic [WIDTH-1:0]        stab_q, stab_d;
  logic [WIDTH-1:0]        prev_q, prev_d;
  logic [PRIME_STAGES-1:0] prime_q, prime_d;

  always_comb begin
    meta_d  = pin_async;
    stab_d  = meta_q;
    prev_d  = stab_q;
    prime_d = {prime_q[PRIME_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      stab_q  <= '0;
      prev_q  <= '0;
      prime_q <= '0;
    end else begin
      meta_q  <= meta_d;
      stab_q  <= stab_d;
      prev_q  <= prev_d;
      prime_q <= prime_d;
    end
  end

  assign primed = prime_q[PRIME_STAGES-1];
  assign lvl    = stab_q;
  assign rise   = stab_q & ~prev_q & {WIDTH{primed}};
  assign fall   = ~stab_q & prev_q & {WIDTH{primed}};

  assert_primed_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);
endmodule

// File: rtl/eirq_channel.sv
module eirq_channel
  import eirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic primed,
  input  logic lvl,
  input  logic rise,
  input  logic fall,
  input  logic mode,
  input  logic pol,
  input  logic both,
  input  logic ack,
  input  logic sw_clr,
  output logic req
);
  trig_kind_e kind;
  logic       edge_hit;
  logic       level_hit;
  logic       trig_event;
  logic       req_q, req_d;

  assign kind = trig_kind_e'(mode);

  always_comb begin
    if (both)      edge_hit = rise | fall;
    else if (pol)  edge_hit = rise;
    else           edge_hit = fall;
    level_hit = primed & (lvl == pol);
    trig_event = (kind == TRIG_LEVEL) ? level_hit : edge_hit;
  end

  always_comb begin
    req_d = req_q;
    if (ack || sw_clr) req_d = 1'b0;
    if (trig_event)    req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_event |=> req);
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && !trig_event) |=> !req);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && !sw_clr) |=> req);
  assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !trig_event) |=> !req);
  assert_level_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == TRIG_LEVEL) |-> !both);
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] mode,
  output logic [NUM_CH-1:0] pol,
  output logic [NUM_CH-1:0] both,
  output logic [NUM_CH-1:0] sw_clr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_CH);

  logic [NUM_CH-1:0] mode_q, mode_d;
  logic [NUM_CH-1:0] pol_q, pol_d;
  logic [DATA_W-1:0] sel_q, sel_d;
  logic              sel_wr;

  assign sel_wr = wr_en && (addr == SEL_ADDR);

  always_comb begin
    mode_d = mode_q;
    pol_d  = pol_q;
    sel_d  = sel_q;
    sw_clr = '0;
    if (sel_wr) sel_d = wdata;
    for (int i = 0; i < NUM_CH; i++) begin
      if (wr_en && (addr == ADDR_W'(i))) begin
        mode_d[i] = wdata[CTRL_MODE_BIT];
        pol_d[i]  = wdata[CTRL_POL_BIT];
        sw_clr[i] = ~wdata[CTRL_REQ_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
      sel_q  <= '0;
    end else begin
      mode_q <= mode_d;
      pol_q  <= pol_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == SEL_ADDR) rdata = sel_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) begin
        rdata[CTRL_MODE_BIT] = mode_q[i];
        rdata[CTRL_POL_BIT]  = pol_q[i];
        rdata[CTRL_REQ_BIT]  = req[i];
      end
    end
  end

  assign mode = mode_q;
  assign pol  = pol_q;
  assign both = sel_q[NUM_CH-1:0];

  assert_sel_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_q == $past(wdata)));
  assert_cfg_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mode_q) && $stable(pol_q) && $stable(sel_q)));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter  int unsigned NUM_CH = 6,
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_pin,
  input  logic [NUM_CH-1:0] irq_ack,
  output logic [NUM_CH-1:0] irq_req,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [1:0]        rst_pipe_q, rst_pipe_d;
  logic              rst_int_n;
  logic [NUM_CH-1:0] lvl, rise, fall;
  logic              primed;
  logic [NUM_CH-1:0] mode, pol, both, sw_clr;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_int_n = rst_pipe_q[1];

  eirq_sync #(.WIDTH(NUM_CH)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin_async (irq_pin),
    .lvl       (lvl),
    .rise      (rise),
    .fall      (fall),
    .primed    (primed)
  );

  eirq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .req    (irq_req),
    .mode   (mode),
    .pol    (pol),
    .both   (both),
    .sw_clr (sw_clr),
    .rdata  (reg_rdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    eirq_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .primed (primed),
      .lvl    (lvl[g]),
      .rise   (rise[g]),
      .fall   (fall[g]),
      .mode   (mode[g]),
      .pol    (pol[g]),
      .both   (both[g]),
      .ack    (irq_ack[g]),
      .sw_clr (sw_clr[g]),
      .req    (irq_req[g])
    );
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_int_n |=> (irq_req == '0));
  assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(irq_ack));
endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] irq_pin;
  logic [5:0] irq_ack;
  logic [5:0] irq_req;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .irq_ack(irq_ack),
    .irq_req(irq_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pin_set(input int ch, input logic v);
    @(negedge clk);
    irq_pin[ch] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack(input int ch);
    @(negedge clk);
    irq_ack[ch] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irq_ack = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(irq_req == 6'h00, "R1 req after reset", irq_req, 0);
    for (int a = 0; a <= 6; a++) begin
      rd(3'(a), d);
      chk(d == 8'h00, "R1 register after reset", d, 0);
    end
  endtask

  task automatic t_falling();
    pin_set(0, 1'b1);
    chk(irq_req == 6'h00, "R2 rising edge ignored in falling mode", irq_req, 0);
    pin_set(0, 1'b0);
    chk(irq_req == 6'h01, "R2 R10 falling edge sets only ch0", irq_req, 6'h01);
    ack(0);
    chk(irq_req == 6'h00, "R6 ack clears ch0", irq_req, 0);
  endtask

  task automatic t_rising_latency();
    logic [7:0] d;
    wr(3'd1, 8'h02);
    @(negedge clk);
    irq_pin[1] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(irq_req[1] == 1'b0, "R11 not yet after two edges", irq_req[1], 0);
    @(posedge clk);
    @(negedge clk);
    chk(irq_req[1] == 1'b1, "R11 R3 set after third edge", irq_req[1], 1);
    rd(3'd1, d);
    chk(d == 8'h06, "R7 flag bit 2 reads back", d, 8'h06);
    ack(1);
    pin_set(1, 1'b0);
    chk(irq_req == 6'h00, "R3 falling edge ignored in rising mode", irq_req, 0);
  endtask

  task automatic t_both();
    wr(3'd6, 8'h04);
    pin_set(2, 1'b1);
    chk(irq_req == 6'h04, "R4 rising edge in both mode", irq_req, 6'h04);
    ack(2);
    pin_set(2, 1'b0);
    chk(irq_req == 6'h04, "R4 falling edge in both mode", irq_req, 6'h04);
    ack(2);
    chk(irq_req == 6'h00, "R6 ack clears ch2", irq_req, 0);
  endtask

  task automatic t_level();
    wr(3'd3, 8'h03);
    repeat (3) @(negedge clk);
    chk(irq_req[3] == 1'b0, "R5 low pin does not meet high level", irq_req[3], 0);
    pin_set(3, 1'b1);
    chk(irq_req[3] == 1'b1, "R5 high level sets", irq_req[3], 1);
    pin_set(3, 1'b0);
    chk(irq_req[3] == 1'b1, "R5 flag held after pin leaves level", irq_req[3], 1);
    ack(3);
    chk(irq_req[3] == 1'b0, "R6 ack clears level channel", irq_req[3], 0);
  endtask

  task automatic t_ack_own();
    pin_set(0, 1'b1);
    pin_set(4, 1'b1);
    pin_set(0, 1'b0);
    pin_set(4, 1'b0);
    chk(irq_req == 6'h11, "R10 two channels set", irq_req, 6'h11);
    ack(0);
    chk(irq_req == 6'h10, "R6 ack clears only its channel", irq_req, 6'h10);
  endtask

  task automatic t_software();
    logic [7:0] d;
    wr(3'd5, 8'h04);
    @(negedge clk);
    chk(irq_req[5] == 1'b0, "R7 write of one does not set", irq_req[5], 0);
    rd(3'd5, d);
    chk(d == 8'h00, "R7 flag still reads zero", d, 0);
    wr(3'd4, 8'h04);
    chk(irq_req[4] == 1'b1, "R7 write of one keeps set flag", irq_req[4], 1);
    wr(3'd4, 8'h00);
    chk(irq_req[4] == 1'b0, "R7 write of zero clears", irq_req[4], 0);
  endtask

  task automatic t_set_wins();
    pin_set(2, 1'b1);
    chk(irq_req[2] == 1'b1, "R8 setup flag set", irq_req[2], 1);
    @(negedge clk);
    irq_pin[2] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    irq_ack[2] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irq_ack = '0;
    chk(irq_req[2] == 1'b1, "R8 event beats same-cycle ack", irq_req[2], 1);
    ack(2);
    chk(irq_req[2] == 1'b0, "R8 later ack clears", irq_req[2], 0);
  endtask

  task automatic t_sel_high();
    logic [7:0] d;
    wr(3'd6, 8'hC4);
    rd(3'd6, d);
    chk(d == 8'hC4, "R9 upper select bits read back", d, 8'hC4);
    pin_set(0, 1'b1);
    chk(irq_req == 6'h00, "R9 upper bits do not enable both edges", irq_req, 0);
    pin_set(0, 1'b0);
    ack(0);
  endtask

  initial begin
    rst_n = 1'b0; irq_pin = '0; irq_ack = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_falling();
    t_rising_latency();
    t_both();
    t_level();
    t_ack_own();
    t_software();
    t_set_wins();
    t_sel_high();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule